// File: doc/BRIEF.md
# Dependency-Gated Process Dispatcher for Four Cores

This block turns a stream of 16-bit scheduler words into a table of up to sixteen processes and issues each process to a free core once everything it waits on has finished. Every process entry holds an enable flag, a start address, a length in instructions and a row of wait bits, one bit for each other process. A word that reports a finished process clears that process from every row. That can release the processes that were waiting on it.

The block has three phases. After reset it idles until `init_go` says a setup block is on its way. It then accepts setup words that open processes, load their address and length, and add or remove wait links. An end-of-setup word switches it to dispatch. From then on, every cycle it takes the lowest-numbered ready process and pairs it with the lowest-numbered free core. Four clock edges later that core sees a one-cycle reset pulse, then a one-cycle init pulse together with the address and length. A core stays busy until its `core_done` bit pulses.

The instruction input is a valid/ready stream. `instr_ready` is low while the block idles, so the source must hold the word and `instr_valid` steady until it sees `instr_ready`. `instr_ready` is high in the setup and dispatch phases, and a word is consumed on any clock edge where `instr_valid` and `instr_ready` are both high. The block never stalls a word once it leaves the idle phase.

Top module: `dep_sched`

## Requirements
- R1: While reset is held, and on its release, `core_rst`, `core_init`, `core_addr` and `core_len` are zero and `instr_ready` is low.
- R2: `instr_ready` stays low until `init_go` is sampled high. From the next cycle it stays high, and a word is consumed on each edge where `instr_valid` and `instr_ready` are both high.
- R3: Only words with bits [15:12] = 1111 act. Bits [11:8] are the target process, bits [7:4] the second process and bits [3:0] the function. Words with any other top nibble are consumed and have no effect.
- R4: Function 0000 opens the target process: it sets its enable flag and makes it the current process. Function 0011 loads bits [11:4] as the start address of the current process. Function 0100 loads bits [11:4] as its length. Function 1000 closes the current process, and address or length words that follow a close are ignored.
- R5: Function 0001 makes the target process wait for the second process. Function 0010 removes that wait.
- R6: No core reset or init pulse occurs before the end-of-setup word (function 1111) has been consumed.
- R7: A process is ready when it is enabled and waits on nothing. A consumed word with function 1110 marks its target process finished and clears it from the wait list of every process.
- R8: When several processes are ready, the lowest-numbered one goes first. It goes to the lowest-numbered free core, and at most one process is issued per cycle.
- R9: If a process becomes ready at clock edge E and a core is free, that core's `core_rst` bit is high for one cycle after edge E+3. Its `core_init` bit is high for one cycle after edge E+4, with that process's address and length on the core's slices of `core_addr` and `core_len`.
- R10: A core that has been issued a process gets nothing more until its `core_done` bit has pulsed.
- R11: Each opened process is issued at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_go | input | 1 | Setup block is arriving; leave the idle phase |
| instr_valid | input | 1 | Scheduler word valid |
| instr_ready | output | 1 | Block accepts a scheduler word |
| instr_data | input | 16 | Scheduler word |
| core_done | input | N_CORE | One-cycle pulse per core: core has become free |
| core_rst | output | N_CORE | One-cycle reset pulse to the chosen core |
| core_init | output | N_CORE | One-cycle start pulse to the chosen core |
| core_addr | output | N_CORE*8 | Start address per core, 8 bits per core, core 0 in the low byte |
| core_len | output | N_CORE*8 | Process length per core, 8 bits per core, core 0 in the low byte |

## Verification
The bench uses the default build: sixteen table entries and four cores. With those values a round can fill every core and still leave processes queued behind busy cores, which is how the busy-hold and lowest-first rules are reached. Random rounds open between five and sixteen processes, up to the full table, with random addresses and lengths, so the table boundary is covered. The directed part shows a removed wait link releasing a process early, and a chained process held back until its predecessor reports done.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int PID_W = 4;
  localparam int VAL_W = 8;
  localparam logic [3:0] OPC_SCHED = 4'hF;

  typedef enum logic [3:0] {
    FN_OPEN     = 4'h0,
    FN_WAIT_ADD = 4'h1,
    FN_WAIT_DEL = 4'h2,
    FN_SET_ADDR = 4'h3,
    FN_SET_LEN  = 4'h4,
    FN_CLOSE    = 4'h8,
    FN_FINISH   = 4'hE,
    FN_GO       = 4'hF
  } fn_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN} st_e;

  typedef struct packed {
    logic open;
    logic wait_add;
    logic wait_del;
    logic set_addr;
    logic set_len;
    logic close;
    logic finish;
    logic go;
  } cmd_t;
endpackage

// File: rtl/sched_decode.sv
module sched_decode
  import sched_pkg::*;
(
  input  logic [15:0]      word,
  input  logic             fire,
  output cmd_t             cmd,
  output logic [PID_W-1:0] tgt,
  output logic [PID_W-1:0] src,
  output logic [VAL_W-1:0] val
);
  logic hit;
  assign hit = fire && (word[15:12] == OPC_SCHED);
  assign tgt = word[11:8];
  assign src = word[7:4];
  assign val = word[11:4];

  always_comb begin
    cmd = '0;
    if (hit) begin
      case (word[3:0])
        FN_OPEN:     cmd.open     = 1'b1;
        FN_WAIT_ADD: cmd.wait_add = 1'b1;
        FN_WAIT_DEL: cmd.wait_del = 1'b1;
        FN_SET_ADDR: cmd.set_addr = 1'b1;
        FN_SET_LEN:  cmd.set_len  = 1'b1;
        FN_CLOSE:    cmd.close    = 1'b1;
        FN_FINISH:   cmd.finish   = 1'b1;
        FN_GO:       cmd.go       = 1'b1;
        default:     cmd = '0;
      endcase
    end
  end
endmodule

// File: rtl/sched_table.sv
module sched_table
  import sched_pkg::*;
#(
  parameter int N_PROC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_open,
  input  logic              do_wait_add,
  input  logic              do_wait_del,
  input  logic              do_set_addr,
  input  logic              do_set_len,
  input  logic              do_close,
  input  logic              do_finish,
  input  logic              run,
  input  logic [PID_W-1:0]  tgt,
  input  logic [PID_W-1:0]  src,
  input  logic [VAL_W-1:0]  val,
  input  logic              take,
  input  logic [PID_W-1:0]  take_pid,
  output logic [N_PROC-1:0] ready_vec,
  output logic [VAL_W-1:0]  take_addr,
  output logic [VAL_W-1:0]  take_len
);
  logic [N_PROC-1:0] en_q;
  logic [N_PROC-1:0] wait_q [N_PROC];
  logic [VAL_W-1:0]  addr_q [N_PROC];
  logic [VAL_W-1:0]  len_q  [N_PROC];
  logic [PID_W-1:0]  cur_q;
  logic              cur_vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      cur_q     <= '0;
      cur_vld_q <= 1'b0;
      for (int i = 0; i < N_PROC; i++) begin
        wait_q[i] <= '0;
        addr_q[i] <= '0;
        len_q[i]  <= '0;
      end
    end else begin
      if (do_open) begin
        en_q[tgt] <= 1'b1;
        cur_q     <= tgt;
        cur_vld_q <= 1'b1;
      end
      if (do_close) cur_vld_q <= 1'b0;
      if (do_set_addr && cur_vld_q) addr_q[cur_q] <= val;
      if (do_set_len && cur_vld_q) len_q[cur_q] <= val;
      if (do_wait_add) wait_q[tgt][src] <= 1'b1;
      if (do_wait_del) wait_q[tgt][src] <= 1'b0;
      if (do_finish) begin
        for (int i = 0; i < N_PROC; i++) wait_q[i][tgt] <= 1'b0;
      end
      if (take) en_q[take_pid] <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < N_PROC; g++) begin : g_rdy
      assign ready_vec[g] = run && en_q[g] && (wait_q[g] == '0);
    end
  endgenerate

  assign take_addr = addr_q[take_pid];
  assign take_len  = len_q[take_pid];
endmodule

// File: rtl/sched_pick.sv
module sched_pick
  import sched_pkg::*;
#(
  parameter int N_PROC = 16,
  parameter int N_CORE = 4,
  localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PROC-1:0] ready_vec,
  input  logic [N_CORE-1:0] core_done,
  output logic              take,
  output logic [PID_W-1:0]  take_pid,
  output logic [CORE_W-1:0] take_core
);
  logic [N_CORE-1:0] busy_q;
  logic              pid_hit, core_hit;

  always_comb begin
    pid_hit  = 1'b0;
    take_pid = '0;
    for (int i = N_PROC - 1; i >= 0; i--) begin
      if (ready_vec[i]) begin
        pid_hit  = 1'b1;
        take_pid = PID_W'(i);
      end
    end
  end

  always_comb begin
    core_hit  = 1'b0;
    take_core = '0;
    for (int c = N_CORE - 1; c >= 0; c--) begin
      if (!busy_q[c]) begin
        core_hit  = 1'b1;
        take_core = CORE_W'(c);
      end
    end
  end

  assign take = pid_hit && core_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else busy_q <= (busy_q & ~core_done) | (take ? (N_CORE'(1) << take_core) : '0);
  end
endmodule

// File: rtl/sched_issue.sv
module sched_issue
  import sched_pkg::*;
#(
  parameter int N_CORE = 4,
  localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic [CORE_W-1:0]       take_core,
  input  logic [VAL_W-1:0]        take_addr,
  input  logic [VAL_W-1:0]        take_len,
  output logic [N_CORE-1:0]       core_rst,
  output logic [N_CORE-1:0]       core_init,
  output logic [N_CORE*VAL_W-1:0] core_addr,
  output logic [N_CORE*VAL_W-1:0] core_len
);
  logic              s1_vld, s2_vld, s3_vld;
  logic [CORE_W-1:0] s1_core, s2_core, s3_core;
  logic [VAL_W-1:0]  s1_addr, s2_addr, s3_addr;
  logic [VAL_W-1:0]  s1_len, s2_len, s3_len;
  logic [VAL_W-1:0]  addr_q [N_CORE];
  logic [VAL_W-1:0]  len_q  [N_CORE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s2_vld <= 1'b0; s3_vld <= 1'b0;
      s1_core <= '0; s2_core <= '0; s3_core <= '0;
      s1_addr <= '0; s2_addr <= '0; s3_addr <= '0;
      s1_len <= '0; s2_len <= '0; s3_len <= '0;
      core_rst  <= '0;
      core_init <= '0;
      for (int c = 0; c < N_CORE; c++) begin
        addr_q[c] <= '0;
        len_q[c]  <= '0;
      end
    end else begin
      s1_vld <= take; s1_core <= take_core; s1_addr <= take_addr; s1_len <= take_len;
      s2_vld <= s1_vld; s2_core <= s1_core; s2_addr <= s1_addr; s2_len <= s1_len;
      s3_vld <= s2_vld; s3_core <= s2_core; s3_addr <= s2_addr; s3_len <= s2_len;
      core_rst  <= s2_vld ? (N_CORE'(1) << s2_core) : '0;
      core_init <= s3_vld ? (N_CORE'(1) << s3_core) : '0;
      if (s3_vld) begin
        addr_q[s3_core] <= s3_addr;
        len_q[s3_core]  <= s3_len;
      end
    end
  end

  generate
    for (genvar g = 0; g < N_CORE; g++) begin : g_out
      assign core_addr[g*VAL_W +: VAL_W] = addr_q[g];
      assign core_len[g*VAL_W +: VAL_W]  = len_q[g];
    end
  endgenerate
endmodule

// File: rtl/dep_sched.sv
module dep_sched
  import sched_pkg::*;
#(
  parameter int N_PROC = 16,
  parameter int N_CORE = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    init_go,
  input  logic                    instr_valid,
  output logic                    instr_ready,
  input  logic [15:0]             instr_data,
  input  logic [N_CORE-1:0]       core_done,
  output logic [N_CORE-1:0]       core_rst,
  output logic [N_CORE-1:0]       core_init,
  output logic [N_CORE*VAL_W-1:0] core_addr,
  output logic [N_CORE*VAL_W-1:0] core_len
);
  localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1;

  st_e               st_q;
  logic              fire, in_setup, in_run;
  cmd_t              cmd;
  logic [PID_W-1:0]  tgt, src, take_pid;
  logic [VAL_W-1:0]  val, take_addr, take_len;
  logic [N_PROC-1:0] ready_vec;
  logic              take;
  logic [CORE_W-1:0] take_core;

  assign instr_ready = (st_q != ST_IDLE);
  assign fire        = instr_valid && instr_ready;
  assign in_setup    = (st_q == ST_SETUP);
  assign in_run      = (st_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else begin
      case (st_q)
        ST_IDLE:  if (init_go) st_q <= ST_SETUP;
        ST_SETUP: if (cmd.go) st_q <= ST_RUN;
        default:  st_q <= ST_RUN;
      endcase
    end
  end

  sched_decode u_dec (
    .word(instr_data), .fire(fire), .cmd(cmd), .tgt(tgt), .src(src), .val(val)
  );

  sched_table #(.N_PROC(N_PROC)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .do_open(cmd.open && in_setup),
    .do_wait_add(cmd.wait_add && in_setup),
    .do_wait_del(cmd.wait_del && in_setup),
    .do_set_addr(cmd.set_addr && in_setup),
    .do_set_len(cmd.set_len && in_setup),
    .do_close(cmd.close && in_setup),
    .do_finish(cmd.finish && in_run),
    .run(in_run), .tgt(tgt), .src(src), .val(val),
    .take(take), .take_pid(take_pid),
    .ready_vec(ready_vec), .take_addr(take_addr), .take_len(take_len)
  );

  sched_pick #(.N_PROC(N_PROC), .N_CORE(N_CORE)) u_pick (
    .clk(clk), .rst_n(rst_n), .ready_vec(ready_vec), .core_done(core_done),
    .take(take), .take_pid(take_pid), .take_core(take_core)
  );

  sched_issue #(.N_CORE(N_CORE)) u_issue (
    .clk(clk), .rst_n(rst_n), .take(take), .take_core(take_core),
    .take_addr(take_addr), .take_len(take_len),
    .core_rst(core_rst), .core_init(core_init),
    .core_addr(core_addr), .core_len(core_len)
  );
endmodule

// File: rtl/dep_sched_chk.sv
module dep_sched_chk #(
  parameter int N_CORE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_run,
  input logic              instr_ready,
  input logic [N_CORE-1:0] core_rst,
  input logic [N_CORE-1:0] core_init
);
  // R8
  init_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_init));

  // R8
  rst_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_rst));

  // R9
  init_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_init != '0) |-> ($past(core_rst) == core_init));

  // R9
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst != '0) |=> ((core_rst & $past(core_rst)) == '0));

  // R6
  no_early_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst != '0) |-> in_run);

  // R2
  ready_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> instr_ready);
endmodule

bind dep_sched dep_sched_chk #(.N_CORE(N_CORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_run(in_run), .instr_ready(instr_ready),
  .core_rst(core_rst), .core_init(core_init)
);

// File: tb/dep_sched_test.sv
`timescale 1ns/1ps
module dep_sched_test;
  localparam int NC = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_go = 1'b0;
  logic instr_valid = 1'b0;
  logic instr_ready;
  logic [15:0] instr_data = '0;
  logic [NC-1:0] core_done = '0;
  logic [NC-1:0] core_rst, core_init;
  logic [NC*8-1:0] core_addr, core_len;

  int nvec = 0;
  int nerr = 0;
  bit finished = 0;

  int ev_n = 0;
  int ev_core [256];
  logic [7:0] ev_addr [256];
  logic [7:0] ev_len [256];

  always #4 clk = ~clk;

  dep_sched uut (
    .clk(clk), .rst_n(rst_n), .init_go(init_go), .instr_valid(instr_valid),
    .instr_ready(instr_ready), .instr_data(instr_data), .core_done(core_done),
    .core_rst(core_rst), .core_init(core_init), .core_addr(core_addr), .core_len(core_len)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NC; c++) begin
        if (core_init[c]) begin
          ev_core[ev_n % 256] = c;
          ev_addr[ev_n % 256] = core_addr[c*8 +: 8];
          ev_len[ev_n % 256]  = core_len[c*8 +: 8];
          ev_n = ev_n + 1;
        end
      end
    end
  end

  function automatic logic [15:0] w_pp(input logic [3:0] fn, input logic [3:0] id, input logic [3:0] rt);
    return {4'hF, id, rt, fn};
  endfunction

  function automatic logic [15:0] w_val(input logic [3:0] fn, input logic [7:0] v);
    return {4'hF, v, fn};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    instr_data  = w;
    instr_valid = 1'b1;
    @(posedge clk);
    #1 instr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_ev(input string req, input int idx, input int c, input logic [7:0] a, input logic [7:0] l);
    chk({req, " event present"}, 32'(idx < ev_n), 32'd1);
    if (idx < ev_n) begin
      chk({req, " core"}, ev_core[idx % 256], c);
      chk({req, " addr"}, ev_addr[idx % 256], a);
      chk({req, " len"}, ev_len[idx % 256], l);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    init_go = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic open_proc(input logic [3:0] p, input logic [7:0] a, input logic [7:0] l);
    send(w_pp(4'h0, p, 4'h0));
    send(w_val(4'h3, a));
    send(w_val(4'h4, l));
    send(w_pp(4'h8, p, 4'h0));
  endtask

  initial begin : main
    int base;
    int seed;
    // directed part
    do_reset();
    @(negedge clk);
    chk("R1 core_rst after reset", core_rst, 0);
    chk("R1 core_init after reset", core_init, 0);
    chk("R1 core_addr after reset", core_addr, 0);
    chk("R1 instr_ready after reset", instr_ready, 0);
    idle(5);
    @(negedge clk);
    chk("R2 ready stays low while idle", instr_ready, 0);
    init_go = 1'b1;
    @(posedge clk);
    #1 init_go = 1'b0;
    @(negedge clk);
    chk("R2 ready high after init_go", instr_ready, 1);

    base = ev_n;
    open_proc(4'd0, 8'h10, 8'd5);
    send(w_pp(4'h0, 4'd1, 4'h0));
    send(w_pp(4'h1, 4'd1, 4'd0));
    send(w_val(4'h3, 8'h21));
    send(w_val(4'h4, 8'd6));
    send(w_pp(4'h8, 4'd1, 4'h0));
    send(w_pp(4'h0, 4'd2, 4'h0));
    send(w_pp(4'h1, 4'd2, 4'd0));
    send(w_pp(4'h1, 4'd2, 4'd1));
    send(w_pp(4'h2, 4'd2, 4'd1));
    send(w_val(4'h3, 8'h32));
    send(w_val(4'h4, 8'd7));
    send(w_pp(4'h8, 4'd2, 4'h0));
    send(w_val(4'h3, 8'hFF));
    send(w_pp(4'h0, 4'd3, 4'h0));
    send(w_pp(4'h1, 4'd3, 4'd2));
    send(w_val(4'h3, 8'h43));
    send(w_val(4'h4, 8'd8));
    send(w_pp(4'h8, 4'd3, 4'h0));
    send({4'h7, 4'd5, 4'h0, 4'h0});
    idle(8);
    @(negedge clk);
    chk("R6 no issue before end of setup", ev_n - base, 0);
    chk("R6 no core reset before end of setup", core_rst, 0);

    send(w_pp(4'hF, 4'h0, 4'h0));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 no reset two edges after ready", core_rst, 0);
    @(negedge clk);
    chk("R9 reset pulse on core 0", core_rst, 4'b0001);
    chk("R9 no init with reset", core_init, 0);
    @(negedge clk);
    chk("R9 init pulse on core 0", core_init, 4'b0001);
    chk("R9 reset is one cycle", core_rst, 0);
    chk("R9 address on core 0", core_addr[7:0], 8'h10);
    chk("R9 length on core 0", core_len[7:0], 8'd5);
    idle(3);
    chk("R7 dependents held while P0 runs", ev_n - base, 1);

    send(w_pp(4'hE, 4'd0, 4'h0));
    idle(10);
    chk_ev("R8 lowest ready first to core 1", base + 1, 1, 8'h21, 8'd6);
    chk_ev("R5 removed wait lets P2 go, R4 closed addr ignored", base + 2, 2, 8'h32, 8'd7);
    idle(8);
    chk("R7 P3 held by P2", ev_n - base, 3);

    send(w_pp(4'hE, 4'd2, 4'h0));
    idle(10);
    chk_ev("R7 finish of P2 releases P3", base + 3, 3, 8'h43, 8'd8);
    send(w_pp(4'hE, 4'd1, 4'h0));
    send(w_pp(4'hE, 4'd3, 4'h0));
    core_done = 4'b1111;
    @(posedge clk);
    #1 core_done = '0;
    idle(12);
    chk("R3 foreign opcode ignored, R11 no reissue", ev_n - base, 4);

    // random rounds
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    for (int round = 0; round < 4; round++) begin
      int np;
      int next;
      int running;
      int core_pid [NC];
      logic [7:0] ra [16];
      logic [7:0] rl [16];
      do_reset();
      init_go = 1'b1;
      @(posedge clk);
      #1 init_go = 1'b0;
      base = ev_n;
      np = (round == 3) ? 16 : 5 + int'($urandom % 12);
      for (int p = 0; p < np; p++) begin
        ra[p] = {4'($urandom), 4'(p)};
        rl[p] = 8'($urandom);
        if (($urandom % 3) == 0) send({4'($urandom % 15), 12'($urandom)});
        open_proc(4'(p), ra[p], rl[p]);
      end
      send(w_pp(4'hF, 4'h0, 4'h0));
      idle(12);
      next = 0;
      running = 0;
      for (int c = 0; c < NC; c++) begin
        if (next < np) begin
          chk_ev("R8 random initial fill", base + next, c, ra[next], rl[next]);
          core_pid[c] = next;
          next++;
          running++;
        end else begin
          core_pid[c] = -1;
        end
      end
      chk("R10 full cores hold queue", ev_n - base, next);
      while (running > 0) begin
        int c;
        c = int'($urandom % NC);
        while (core_pid[c] < 0) c = (c + 1) % NC;
        send(w_pp(4'hE, 4'(core_pid[c]), 4'h0));
        idle(6);
        chk("R10 no issue to busy core", ev_n - base, next);
        core_done[c] = 1'b1;
        @(posedge clk);
        #1 core_done[c] = 1'b0;
        idle(8);
        if (next < np) begin
          chk_ev("R10 freed core takes next", base + next, c, ra[next], rl[next]);
          core_pid[c] = next;
          next++;
        end else begin
          core_pid[c] = -1;
          running--;
        end
      end
      idle(8);
      chk("R11 each process issued once", ev_n - base, np);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule